// File: doc/BRIEF.md
# Chained Fixed-Point Multiply-Subtract Pipeline

This block evaluates four dependent signed fixed-point equations from seven signed operands, a through g. The first result is a*b − c. Each later result builds on the earlier ones: p2 = p1*d − e, p3 = p2*f − g, and p4 = p2*p1 − p3. The width of every intermediate value comes from parameter arithmetic on the operand widths. A product is as wide as its two operands together, and a subtraction adds one bit. Changing an operand width therefore resizes the whole chain with no manual edits.

Each equation is registered in its own stage. The operands that a later stage needs travel down the pipe alongside the partial results. A sample is accepted when `valid_in` is high, and all four results appear together, with `valid_out`, four cycles later. Samples may arrive back to back.

A single parameter `TRUNC_W` limits bit growth. When it is nonzero, p2 and p3 are each cut down to their top `TRUNC_W` bits, and the downstream stages use those shortened values. `TRUNC_W` must not exceed the full width of p2 or the full width of p3. All arithmetic is written as plain expressions, so synthesis can map it onto ordinary multipliers and adders.

Top module: `chain_msub`

## Requirements
- R1: `p1_o` equals a*b − c computed as signed values, with width P1W = max(AW+BW, CW) + 1. With c sign-extended to P1W, no operand value overflows it, including −2^(W−1).
- R2: With `TRUNC_W` = 0, `p2_o` equals p1*d − e, with width P2W = max(P1W+DW, EW) + 1.
- R3: With `TRUNC_W` = 0, `p3_o` equals p2*f − g, with width P3W = max(P2W+FW, GW) + 1.
- R4: `p4_o` equals p2*p1 − p3, where p2 and p3 are the values presented on `p2_o` and `p3_o`. Its width is P4W = max(P2W+P1W, P3W) + 1.
- R5: A sample accepted on a rising clock edge with `valid_in` = 1 produces `valid_out` = 1, with its four results, exactly 4 rising edges later.
- R6: Samples on consecutive cycles each produce one result, in order, with no gaps.
- R7: While `valid_out` is 0, all four result outputs hold the last values they presented.
- R8: When `TRUNC_W` is nonzero, let p2f and p3f be the full-precision values and P2F and P3F their full widths. Then p2 = p2f >>> (P2F − TRUNC_W) and p3 = p3f >>> (P3F − TRUNC_W), using arithmetic shifts, so both round toward minus infinity. Both are `TRUNC_W` bits wide.
- R9: While `rst` (synchronous, active high) is asserted, and on the first cycle after it is released, `valid_out` is 0 and all result outputs are 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| valid_in | input | 1 | Operands a..g are presented this cycle |
| a_i | input | AW | Signed operand a |
| b_i | input | BW | Signed operand b |
| c_i | input | CW | Signed operand c |
| d_i | input | DW | Signed operand d |
| e_i | input | EW | Signed operand e |
| f_i | input | FW | Signed operand f |
| g_i | input | GW | Signed operand g |
| valid_out | output | 1 | Results for one sample are presented |
| p1_o | output | P1W | a*b − c |
| p2_o | output | P2W | p1*d − e, optionally truncated |
| p3_o | output | P3W | p2*f − g, optionally truncated |
| p4_o | output | P4W | p2*p1 − p3 |

## Verification
The bench pushes operands at their most negative and most positive values through the chain; a derived width one bit short would wrap p1 or a later term and flip the sign of p4. A second instance with truncation enabled is fed negative intermediates, where a logical shift or a rounding toward zero would give results one above the expected floor or with the wrong sign. Back-to-back samples and an isolated sample after a quiet gap expose a stage that loses alignment between its delayed operands and its partial result, which would combine p2 of one sample with p1 of another. Outputs are watched during idle cycles to catch registers that load regardless of valid.

// File: rtl/chain_msub.sv
module chain_msub #(
  parameter int AW = 8,
  parameter int BW = 8,
  parameter int CW = 8,
  parameter int DW = 8,
  parameter int EW = 8,
  parameter int FW = 8,
  parameter int GW = 8,
  parameter int TRUNC_W = 0,
  localparam int M1  = AW + BW,
  localparam int P1W = ((M1 > CW) ? M1 : CW) + 1,
  localparam int M2  = P1W + DW,
  localparam int P2F = ((M2 > EW) ? M2 : EW) + 1,
  localparam int P2W = (TRUNC_W == 0) ? P2F : TRUNC_W,
  localparam int M3  = P2W + FW,
  localparam int P3F = ((M3 > GW) ? M3 : GW) + 1,
  localparam int P3W = (TRUNC_W == 0) ? P3F : TRUNC_W,
  localparam int M4  = P2W + P1W,
  localparam int P4W = ((M4 > P3W) ? M4 : P3W) + 1
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  valid_in,
  input  logic signed [AW-1:0]  a_i,
  input  logic signed [BW-1:0]  b_i,
  input  logic signed [CW-1:0]  c_i,
  input  logic signed [DW-1:0]  d_i,
  input  logic signed [EW-1:0]  e_i,
  input  logic signed [FW-1:0]  f_i,
  input  logic signed [GW-1:0]  g_i,
  output logic                  valid_out,
  output logic signed [P1W-1:0] p1_o,
  output logic signed [P2W-1:0] p2_o,
  output logic signed [P3W-1:0] p3_o,
  output logic signed [P4W-1:0] p4_o
);
  localparam int SH2 = P2F - P2W;
  localparam int SH3 = P3F - P3W;

  logic v1, v2, v3;
  logic signed [P1W-1:0] p1_1, p1_2, p1_3;
  logic signed [P2W-1:0] p2_2, p2_3;
  logic signed [P3W-1:0] p3_3;
  logic signed [DW-1:0]  d1;
  logic signed [EW-1:0]  e1;
  logic signed [FW-1:0]  f1, f2;
  logic signed [GW-1:0]  g1, g2;

  wire signed [P1W-1:0] p1_n  = P1W'(a_i) * P1W'(b_i) - P1W'(c_i);
  wire signed [P2F-1:0] p2f_n = P2F'(p1_1) * P2F'(d1) - P2F'(e1);
  wire signed [P2W-1:0] p2_n  = P2W'(p2f_n >>> SH2);
  wire signed [P3F-1:0] p3f_n = P3F'(p2_2) * P3F'(f2) - P3F'(g2);
  wire signed [P3W-1:0] p3_n  = P3W'(p3f_n >>> SH3);
  wire signed [P4W-1:0] p4_n  = P4W'(p2_3) * P4W'(p1_3) - P4W'(p3_3);

  always_ff @(posedge clk) begin
    if (rst) begin
      v1 <= 1'b0; v2 <= 1'b0; v3 <= 1'b0; valid_out <= 1'b0;
      p1_1 <= '0; d1 <= '0; e1 <= '0; f1 <= '0; g1 <= '0;
      p2_2 <= '0; p1_2 <= '0; f2 <= '0; g2 <= '0;
      p3_3 <= '0; p2_3 <= '0; p1_3 <= '0;
      p1_o <= '0; p2_o <= '0; p3_o <= '0; p4_o <= '0;
    end else begin
      v1 <= valid_in;
      v2 <= v1;
      v3 <= v2;
      valid_out <= v3;
      if (valid_in) begin
        p1_1 <= p1_n; d1 <= d_i; e1 <= e_i; f1 <= f_i; g1 <= g_i;
      end
      if (v1) begin
        p2_2 <= p2_n; p1_2 <= p1_1; f2 <= f1; g2 <= g1;
      end
      if (v2) begin
        p3_3 <= p3_n; p2_3 <= p2_2; p1_3 <= p1_2;
      end
      if (v3) begin
        p4_o <= p4_n; p3_o <= p3_3; p2_o <= p2_3; p1_o <= p1_3;
      end
    end
  end

  // R5
  latency_fwd_chk: assert property (@(posedge clk) disable iff (rst)
    valid_in |-> ##4 valid_out);

  // R6
  latency_back_chk: assert property (@(posedge clk) disable iff (rst)
    valid_out |-> $past(valid_in, 4));

  // R7
  hold_idle_chk: assert property (@(posedge clk) disable iff (rst)
    !valid_out |-> ($stable(p1_o) && $stable(p2_o) && $stable(p3_o) && $stable(p4_o)));

  // R4
  p4_reuse_chk: assert property (@(posedge clk) disable iff (rst)
    valid_out |-> (p4_o == (P4W'(p2_o) * P4W'(p1_o) - P4W'(p3_o))));

  // R9
  reset_clear_chk: assert property (@(posedge clk)
    rst |=> (!valid_out && p4_o == '0 && p1_o == '0));
endmodule

// File: tb/chain_msub_tb.sv
`timescale 1ns/1ps
module chain_msub_tb;
  localparam int NV = 10;
  localparam int NR = 24;
  localparam int TW = 12;
  localparam int F1W = 17, F2W = 26, F3W = 35, F4W = 44;
  localparam int T2F = 26, T3F = TW + 8 + 1, T4W = TW + 17 + 1;
  localparam int SH2 = T2F - TW, SH3 = T3F - TW;

  localparam int VEC [NV][7] = '{
    '{0, 0, 0, 0, 0, 0, 0},
    '{1, 1, 0, 1, 0, 1, 0},
    '{-128, -128, -128, -128, -128, -128, -128},
    '{127, 127, 127, 127, 127, 127, 127},
    '{-128, -128, 127, -128, 127, -128, 127},
    '{-128, 127, -128, 127, -128, 127, -128},
    '{3, -5, 7, -2, 11, 4, -9},
    '{-1, -1, -1, -1, -1, -1, -1},
    '{100, -77, 55, -33, 22, -11, 5},
    '{-128, -128, 127, 127, -128, -128, 127}
  };

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic valid_in = 1'b0;
  logic signed [7:0] a, b, c, d, e, f, g;
  logic vo, vo_t;
  logic signed [F1W-1:0] p1, p1_t;
  logic signed [F2W-1:0] p2;
  logic signed [F3W-1:0] p3;
  logic signed [F4W-1:0] p4;
  logic signed [TW-1:0]  p2_t, p3_t;
  logic signed [T4W-1:0] p4_t;

  int checks = 0, fails = 0, cyc = 0, sent = 0, rcv = 0;
  int unsigned seed = 32'h1234_5678;
  longint exp_f [0:63][0:3];
  longint exp_t [0:63][0:3];
  int send_cyc [0:63];

  always #2.5 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  initial begin
    a = 0; b = 0; c = 0; d = 0; e = 0; f = 0; g = 0;
  end

  chain_msub u_dut (
    .clk(clk), .rst(rst), .valid_in(valid_in),
    .a_i(a), .b_i(b), .c_i(c), .d_i(d), .e_i(e), .f_i(f), .g_i(g),
    .valid_out(vo), .p1_o(p1), .p2_o(p2), .p3_o(p3), .p4_o(p4));

  chain_msub #(.TRUNC_W(TW)) u_dut_trunc (
    .clk(clk), .rst(rst), .valid_in(valid_in),
    .a_i(a), .b_i(b), .c_i(c), .d_i(d), .e_i(e), .f_i(f), .g_i(g),
    .valid_out(vo_t), .p1_o(p1_t), .p2_o(p2_t), .p3_o(p3_t), .p4_o(p4_t));

  task automatic chk(input string req, input longint act, input longint expv);
    checks++;
    if (act != expv) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, expv);
    end
  endtask

  function automatic void model(input longint ma, mb, mc, md, me, mf, mg,
                                input int s2, input int s3,
                                output longint o1, output longint o2,
                                output longint o3, output longint o4);
    o1 = ma * mb - mc;
    o2 = (o1 * md - me) >>> s2;
    o3 = (o2 * mf - mg) >>> s3;
    o4 = o2 * o1 - o3;
  endfunction

  task automatic drive(input int va, vb, vc, vd, ve, vf, vg);
    longint r1, r2, r3, r4;
    @(negedge clk);
    a = 8'(va); b = 8'(vb); c = 8'(vc); d = 8'(vd);
    e = 8'(ve); f = 8'(vf); g = 8'(vg);
    valid_in = 1'b1;
    model(va, vb, vc, vd, ve, vf, vg, 0, 0, r1, r2, r3, r4);
    exp_f[sent][0] = r1; exp_f[sent][1] = r2; exp_f[sent][2] = r3; exp_f[sent][3] = r4;
    model(va, vb, vc, vd, ve, vf, vg, SH2, SH3, r1, r2, r3, r4);
    exp_t[sent][0] = r1; exp_t[sent][1] = r2; exp_t[sent][2] = r3; exp_t[sent][3] = r4;
    send_cyc[sent] = cyc;
    sent++;
  endtask

  function automatic int rnd8();
    seed = seed * 32'd1103515245 + 32'd12345;
    return int'($signed(seed[23:16]));
  endfunction

  always @(negedge clk) begin
    if (!rst && vo) begin
      chk("R5 latency", longint'(cyc - send_cyc[rcv]), 4);
      chk("R1 p1", longint'(p1), exp_f[rcv][0]);
      chk("R2 p2", longint'(p2), exp_f[rcv][1]);
      chk("R3 p3", longint'(p3), exp_f[rcv][2]);
      chk("R4 p4", longint'(p4), exp_f[rcv][3]);
      chk("R8 valid trunc", longint'(vo_t), 1);
      chk("R1 p1 trunc inst", longint'(p1_t), exp_t[rcv][0]);
      chk("R8 p2 trunc", longint'(p2_t), exp_t[rcv][1]);
      chk("R8 p3 trunc", longint'(p3_t), exp_t[rcv][2]);
      chk("R4 p4 trunc", longint'(p4_t), exp_t[rcv][3]);
      rcv++;
    end
  end

  task automatic finish_up();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  endtask

  initial begin
    #100000;
    checks++;
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_up();
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    // R9 during reset
    chk("R9 valid in reset", longint'(vo), 0);
    chk("R9 p4 in reset", longint'(p4), 0);
    rst = 1'b0;
    @(negedge clk);
    chk("R9 valid after reset", longint'(vo), 0);
    chk("R9 p1 after reset", longint'(p1), 0);
    chk("R9 p3 after reset", longint'(p3), 0);

    // R6 back-to-back stream
    for (int k = 0; k < NV; k++)
      drive(VEC[k][0], VEC[k][1], VEC[k][2], VEC[k][3], VEC[k][4], VEC[k][5], VEC[k][6]);
    for (int k = 0; k < NR; k++)
      drive(rnd8(), rnd8(), rnd8(), rnd8(), rnd8(), rnd8(), rnd8());
    @(negedge clk);
    valid_in = 1'b0;
    repeat (8) @(negedge clk);
    chk("R6 all received", longint'(rcv), longint'(sent));

    // R7 isolated sample then idle gap
    drive(-128, 127, -1, 5, -128, -7, 100);
    @(negedge clk);
    valid_in = 1'b0;
    a = 8'sd99; b = -8'sd99; c = 8'sd1; d = 8'sd2; e = 8'sd3; f = 8'sd4; g = 8'sd5;
    repeat (6) @(negedge clk);
    for (int k = 0; k < 4; k++) begin
      chk("R7 idle valid", longint'(vo), 0);
      chk("R7 hold p1", longint'(p1), exp_f[sent-1][0]);
      chk("R7 hold p2", longint'(p2), exp_f[sent-1][1]);
      chk("R7 hold p3", longint'(p3), exp_f[sent-1][2]);
      chk("R7 hold p4", longint'(p4), exp_f[sent-1][3]);
      chk("R7 hold p4 trunc", longint'(p4_t), exp_t[sent-1][3]);
      @(negedge clk);
    end
    chk("R6 final count", longint'(rcv), longint'(sent));
    finish_up();
  end
endmodule